// File: doc/BRIEF.md
# Dual-FIFO Processor Mailbox

This block connects an application processor and an I/O co-processor through two independent message queues. The outbound queue carries messages from the application side to the I/O side. The inbound queue carries messages in the opposite direction. Each message is 96 bits wide: a 64-bit upper word and a 32-bit lower word. A sender first writes the upper word into a per-port staging register. Writing the lower word then enqueues the whole message. A receiver may peek the upper word, and reading the lower word dequeues the entry.

Both processors reach the same register map through their own simple single-cycle register port. Write data is captured on the clock edge. Read data is combinational while the request is held. Per queue, a status word reports the following:

- full and empty
- the fill level
- a sticky overflow flag

The lower receive word also reports the fill level, the free space and both queue pointers.

A shared interrupt block holds four pending bits, one each for outbound empty, outbound not empty, inbound empty and inbound not empty. Each pending bit latches its condition until it is acknowledged. The bits are gated by an enable register and drive one "send queue empty" line and one "receive queue not empty" line per side.

Top module: `dual_mailbox`

## Requirements
- R1: A message written through its two send words comes out of the same queue intact and in first-in first-out order. The outbound queue (control 0x50, send 0x60/0x68, receive 0x70/0x78) and the inbound queue (control 0x80, send 0x90/0x98, receive 0xA0/0xA8) operate independently.
- R2: A write to the upper send word (0x60/0x90) only loads that port's staging register for that queue, and the queue stays unchanged. A write to the lower send word (0x68/0x98) enqueues {staged word, wdata[31:0]}. The staged word is kept for later messages.
- R3: The queue control word has the following layout:
  - bits 4:0 hold the fill level
  - bit 16 is set when the level is 16 (full)
  - bit 17 is set when the level is 0 (empty)
  - bit 18 is a sticky overflow flag

  An enqueue while full is dropped and sets bit 18. Writing 1 to bit 18 of the control word clears it.
- R4: Reading the lower receive word (0x78/0xA8) dequeues the head entry. Reading the upper receive word (0x70/0xA0) has no side effect. While the queue is empty, both receive words read as zero and the pointers do not move.
- R5: A non-empty read of the lower receive word returns the following, all taken before the dequeue:
  - bits 31:0: the message's lower word
  - bits 39:32: zero
  - bits 43:40: the write pointer
  - bits 47:44: the read pointer
  - bits 51:48: the free entries, capped at 15
  - bits 56:52: the fill level
  - bits 63:57: zero
- R6: Both ports decode the same map. If both ports enqueue into the same queue in one cycle, the application port's message is taken, the I/O port's is dropped, and the overflow flag is set. If both ports dequeue from the same queue in one cycle, exactly one entry is removed and both ports read it.
- R7: The pending bits are bit 0 outbound empty, bit 1 outbound not empty, bit 2 inbound empty and bit 3 inbound not empty.
  - Each pending bit is set while its condition holds, and stays set once the condition has held.
  - Reading 0x4C returns the four pending bits.
  - Writing a 1 to a bit of 0x4C clears that bit's latch. The bit stays pending if its condition is still true.
- R8: The interrupt enable register is bits 3:0 at 0x48. The lines are driven by pending AND enable:
  - ap_irq_send_empty uses bit 0
  - io_irq_recv_ready uses bit 1
  - io_irq_send_empty uses bit 2
  - ap_irq_recv_ready uses bit 3
- R9: Reset leaves the following state:
  - both queues empty, with control words reading 0x20000
  - the enable register at zero
  - all latches and overflow flags cleared
  - all four interrupt lines low

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ap_req | input | 1 | Application port access request |
| ap_we | input | 1 | Application port write (1) or read (0) |
| ap_addr | input | 8 | Application port byte address |
| ap_wdata | input | 64 | Application port write data |
| ap_rdata | output | 64 | Application port read data, valid while the request is held |
| io_req | input | 1 | I/O port access request |
| io_we | input | 1 | I/O port write (1) or read (0) |
| io_addr | input | 8 | I/O port byte address |
| io_wdata | input | 64 | I/O port write data |
| io_rdata | output | 64 | I/O port read data, valid while the request is held |
| ap_irq_send_empty | output | 1 | Application side: outbound queue was or is empty |
| ap_irq_recv_ready | output | 1 | Application side: inbound queue held or holds data |
| io_irq_send_empty | output | 1 | I/O side: inbound queue was or is empty |
| io_irq_recv_ready | output | 1 | I/O side: outbound queue held or holds data |

## Verification
The queues are driven by a seeded random mix of the following operations, weighted first toward filling and later toward draining, so that pointer wraparound, full drops and empty reads all occur:

- enqueues from either port into either queue
- dequeues
- status reads
- overflow clears

Each read is compared against a queue model, which tells a correct pointer and level report apart from a stale or off-by-one one. Directed sequences add the following cases:

- an upper-word write with no enqueue, and reuse of a staged word
- the seventeenth enqueue into a full queue
- peeks on empty and non-empty queues
- same-cycle enqueue and dequeue collisions between the two ports

An interrupt sequence acknowledges pending bits both while their condition is false and while it is still true, which separates a sticky latch from a bare level and from an edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int PTR_W   = 4;
    localparam int DEPTH   = 1 << PTR_W;
    localparam int LVL_W   = PTR_W + 1;
    localparam int W0      = 64;
    localparam int W1      = 32;
    localparam int MSG_W   = W0 + W1;
    localparam int DATA_W  = 64;
    localparam int ADDR_W  = 8;
    localparam int NFIFO   = 2;
    localparam int NPORT   = 2;
    localparam int NIRQ    = 2 * NFIFO;

    localparam int BIT_FULL  = 16;
    localparam int BIT_EMPTY = 17;
    localparam int BIT_OVF   = 18;

    localparam logic [ADDR_W-1:0] ADR_IRQ_EN  = 8'h48;
    localparam logic [ADDR_W-1:0] ADR_IRQ_ACK = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_SEND_HI = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_SEND_LO = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_RECV_HI = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RECV_LO = 8'h28;

    typedef struct packed {
        logic             push;
        logic [MSG_W-1:0] msg;
        logic             pop;
        logic             ovf_clr;
    } fifo_req_t;

    typedef struct packed {
        logic [MSG_W-1:0] head;
        logic [LVL_W-1:0] lvl;
        logic [PTR_W-1:0] rdp;
        logic [PTR_W-1:0] wrp;
        logic             ovf;
    } fifo_stat_t;

    // Queue 0 is outbound (application to I/O), queue 1 is inbound.
    function automatic logic [ADDR_W-1:0] fifo_base(input int f);
        return (f == 0) ? 8'h50 : 8'h80;
    endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
    import mbx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  fifo_req_t [NPORT-1:0] req_i,
    output fifo_stat_t            stat_o
);
    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [LVL_W-1:0] lvl;
        logic             ovf;
    } st_t;

    st_t              st_d, st_q;
    logic [MSG_W-1:0] mem_q [DEPTH];
    logic             wr_en;
    logic [MSG_W-1:0] wr_msg;

    always_comb begin
        logic want, clash, any_pop, clr, full, empty, do_pop;
        st_d    = st_q;
        want    = 1'b0;
        clash   = 1'b0;
        any_pop = 1'b0;
        clr     = 1'b0;
        wr_msg  = '0;
        // Walk downward so the lowest-numbered pushing port wins.
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (req_i[p].push) begin
                if (want) clash = 1'b1;
                want   = 1'b1;
                wr_msg = req_i[p].msg;
            end
            any_pop = any_pop | req_i[p].pop;
            clr     = clr | req_i[p].ovf_clr;
        end
        full   = (st_q.lvl == LVL_W'(DEPTH));
        empty  = (st_q.lvl == '0);
        wr_en  = want && !full;
        do_pop = any_pop && !empty;
        if (wr_en)  st_d.wr = st_q.wr + 1'b1;
        if (do_pop) st_d.rd = st_q.rd + 1'b1;
        st_d.lvl = st_q.lvl + LVL_W'(wr_en) - LVL_W'(do_pop);
        st_d.ovf = (st_q.ovf && !clr) || (want && full) || clash;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[st_q.wr] <= wr_msg;
    end

    assign stat_o = '{head: mem_q[st_q.rd], lvl: st_q.lvl, rdp: st_q.rd,
                      wrp: st_q.wr, ovf: st_q.ovf};
endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  logic                   we_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  fifo_stat_t [NFIFO-1:0] stat_i,
    input  logic [NIRQ-1:0]        en_i,
    input  logic [NIRQ-1:0]        pend_i,
    output fifo_req_t [NFIFO-1:0]  freq_o,
    output logic                   en_we_o,
    output logic [NIRQ-1:0]        en_val_o,
    output logic [NIRQ-1:0]        ack_o,
    output logic [DATA_W-1:0]      rdata_o
);
    typedef struct packed {
        logic [NFIFO-1:0][W0-1:0] stage;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic             wr, rd, empty;
        logic [ADDR_W-1:0] b;
        logic [LVL_W-1:0]  room;
        logic [PTR_W-1:0]  room_c;
        st_d     = st_q;
        wr       = req_i && we_i;
        rd       = req_i && !we_i;
        rdata_o  = '0;
        en_we_o  = wr && (addr_i == ADR_IRQ_EN);
        en_val_o = wdata_i[NIRQ-1:0];
        ack_o    = (wr && addr_i == ADR_IRQ_ACK) ? wdata_i[NIRQ-1:0] : '0;
        if (rd && addr_i == ADR_IRQ_EN)  rdata_o = DATA_W'(en_i);
        if (rd && addr_i == ADR_IRQ_ACK) rdata_o = DATA_W'(pend_i);
        for (int f = 0; f < NFIFO; f++) begin
            b      = fifo_base(f);
            empty  = (stat_i[f].lvl == '0);
            room   = LVL_W'(DEPTH) - stat_i[f].lvl;
            room_c = (room > LVL_W'(DEPTH - 1)) ? '1 : room[PTR_W-1:0];

            freq_o[f].push    = wr && (addr_i == b + OFS_SEND_LO);
            freq_o[f].msg     = {st_q.stage[f], wdata_i[W1-1:0]};
            freq_o[f].pop     = rd && (addr_i == b + OFS_RECV_LO);
            freq_o[f].ovf_clr = wr && (addr_i == b) && wdata_i[BIT_OVF];

            if (wr && addr_i == b + OFS_SEND_HI) st_d.stage[f] = wdata_i[W0-1:0];

            if (rd && addr_i == b) begin
                rdata_o[BIT_OVF]   = stat_i[f].ovf;
                rdata_o[BIT_EMPTY] = empty;
                rdata_o[BIT_FULL]  = (stat_i[f].lvl == LVL_W'(DEPTH));
                rdata_o[LVL_W-1:0] = stat_i[f].lvl;
            end
            if (rd && addr_i == b + OFS_RECV_HI && !empty)
                rdata_o = stat_i[f].head[MSG_W-1:W1];
            if (rd && addr_i == b + OFS_RECV_LO && !empty)
                rdata_o = {7'b0, stat_i[f].lvl, room_c, stat_i[f].rdp,
                           stat_i[f].wrp, 8'b0, stat_i[f].head[W1-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NIRQ-1:0]            cond_i,
    input  logic [NPORT-1:0]           en_we_i,
    input  logic [NPORT-1:0][NIRQ-1:0] en_val_i,
    input  logic [NPORT-1:0][NIRQ-1:0] ack_i,
    output logic [NIRQ-1:0]            en_o,
    output logic [NIRQ-1:0]            pend_o,
    output logic [NIRQ-1:0]            irq_o
);
    typedef struct packed {
        logic [NIRQ-1:0] en;
        logic [NIRQ-1:0] sticky;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [NIRQ-1:0] ack_all;
        st_d    = st_q;
        ack_all = '0;
        // Port 0 is applied last so it wins an enable-write collision.
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (en_we_i[p]) st_d.en = en_val_i[p];
            ack_all = ack_all | ack_i[p];
        end
        st_d.sticky = (st_q.sticky | cond_i) & ~ack_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.sticky | cond_i;
    assign en_o   = st_q.en;
    assign irq_o  = st_q.en & pend_o;
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ap_req,
    input  logic              ap_we,
    input  logic [ADDR_W-1:0] ap_addr,
    input  logic [DATA_W-1:0] ap_wdata,
    output logic [DATA_W-1:0] ap_rdata,
    input  logic              io_req,
    input  logic              io_we,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              ap_irq_send_empty,
    output logic              ap_irq_recv_ready,
    output logic              io_irq_send_empty,
    output logic              io_irq_recv_ready
);
    logic [NPORT-1:0]                         p_req, p_we;
    logic [NPORT-1:0][ADDR_W-1:0]             p_addr;
    logic [NPORT-1:0][DATA_W-1:0]             p_wdata, p_rdata;
    fifo_req_t [NPORT-1:0][NFIFO-1:0]         p_freq;
    fifo_req_t [NFIFO-1:0][NPORT-1:0]         f_req;
    fifo_stat_t [NFIFO-1:0]                   f_stat;
    logic [NPORT-1:0]                         en_we;
    logic [NPORT-1:0][NIRQ-1:0]               en_val, ack;
    logic [NIRQ-1:0]                          en_q, pend, irq, cond;

    // Port 0 is the application side, port 1 the I/O side.
    assign p_req   = {io_req, ap_req};
    assign p_we    = {io_we, ap_we};
    assign p_addr  = {io_addr, ap_addr};
    assign p_wdata = {io_wdata, ap_wdata};
    assign ap_rdata = p_rdata[0];
    assign io_rdata = p_rdata[1];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        mbx_port u_port (
            .clk(clk), .rst_n(rst_n),
            .req_i(p_req[p]), .we_i(p_we[p]), .addr_i(p_addr[p]),
            .wdata_i(p_wdata[p]), .stat_i(f_stat), .en_i(en_q), .pend_i(pend),
            .freq_o(p_freq[p]), .en_we_o(en_we[p]), .en_val_o(en_val[p]),
            .ack_o(ack[p]), .rdata_o(p_rdata[p])
        );
    end

    for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
        for (genvar p = 0; p < NPORT; p++) begin : g_route
            assign f_req[f][p] = p_freq[p][f];
        end
        mbx_fifo u_fifo (
            .clk(clk), .rst_n(rst_n), .req_i(f_req[f]), .stat_o(f_stat[f])
        );
        assign cond[2*f]   = (f_stat[f].lvl == '0);
        assign cond[2*f+1] = (f_stat[f].lvl != '0);
    end

    mbx_irq u_irq (
        .clk(clk), .rst_n(rst_n), .cond_i(cond), .en_we_i(en_we),
        .en_val_i(en_val), .ack_i(ack), .en_o(en_q), .pend_o(pend), .irq_o(irq)
    );

    assign ap_irq_send_empty = irq[0];
    assign io_irq_recv_ready = irq[1];
    assign io_irq_send_empty = irq[2];
    assign ap_irq_recv_ready = irq[3];
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] lvl0,
    input logic [LVL_W-1:0] lvl1,
    input logic [PTR_W-1:0] rdp0,
    input logic [PTR_W-1:0] wrp0,
    input logic [PTR_W-1:0] rdp1,
    input logic [PTR_W-1:0] wrp1,
    input logic [NIRQ-1:0]  en,
    input logic             ap_se,
    input logic             ap_rr,
    input logic             io_se,
    input logic             io_rr
);
    assert_ptr_track_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(wrp0 - rdp0) == lvl0[PTR_W-1:0]) && (PTR_W'(wrp1 - rdp1) == lvl1[PTR_W-1:0]));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl0 <= LVL_W'(DEPTH)) && (lvl1 <= LVL_W'(DEPTH)));

    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl0 == LVL_W'(DEPTH)) |=> ((lvl0 == LVL_W'(DEPTH)) || (rdp0 != $past(rdp0))));

    assert_empty_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl0 == '0) |=> $stable(rdp0));

    assert_empty_still_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl1 == '0) |=> $stable(rdp1));

    assert_ap_send_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl0 == '0) && en[0]) |-> ap_se);

    assert_io_recv_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl0 != '0) && en[1]) |-> io_rr);

    assert_io_send_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl1 == '0) && en[2]) |-> io_se);

    assert_ap_recv_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl1 != '0) && en[3]) |-> ap_rr);

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R9: assert ({ap_se, ap_rr, io_se, io_rr} == 4'b0000)
                else $error("interrupt line active during reset");
        end
    end
endmodule

bind dual_mailbox mbx_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .lvl0(f_stat[0].lvl), .lvl1(f_stat[1].lvl),
    .rdp0(f_stat[0].rdp), .wrp0(f_stat[0].wrp),
    .rdp1(f_stat[1].rdp), .wrp1(f_stat[1].wrp),
    .en(en_q),
    .ap_se(ap_irq_send_empty), .ap_rr(ap_irq_recv_ready),
    .io_se(io_irq_send_empty), .io_rr(io_irq_recv_ready)
);

// File: tb/dual_mailbox_tb.sv
module dual_mailbox_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ap_req, ap_we, io_req, io_we;
    logic [7:0]  ap_addr, io_addr;
    logic [63:0] ap_wdata, io_wdata, ap_rdata, io_rdata;
    logic        ap_irq_send_empty, ap_irq_recv_ready, io_irq_send_empty, io_irq_recv_ready;

    always #5 clk = ~clk;

    dual_mailbox u_dut (
        .clk(clk), .rst_n(rst_n),
        .ap_req(ap_req), .ap_we(ap_we), .ap_addr(ap_addr), .ap_wdata(ap_wdata), .ap_rdata(ap_rdata),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ap_irq_send_empty(ap_irq_send_empty), .ap_irq_recv_ready(ap_irq_recv_ready),
        .io_irq_send_empty(io_irq_send_empty), .io_irq_recv_ready(io_irq_recv_ready)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Queue model.
    logic [95:0] mq [2][$];
    logic [3:0]  mrd [2];
    logic [3:0]  mwr [2];
    bit          movf [2];

    int          op, side, fq, seed;
    logic [95:0] m;
    logic [63:0] v, va, vb, hi;

    function automatic logic [7:0] base(int f);
        return (f == 0) ? 8'h50 : 8'h80;
    endfunction

    function automatic logic [63:0] exp_ctrl(int f);
        logic [63:0] r;
        int n = mq[f].size();
        r = '0;
        r[18] = movf[f];
        r[17] = (n == 0);
        r[16] = (n == 16);
        r[4:0] = 5'(n);
        return r;
    endfunction

    function automatic logic [63:0] exp_hi(int f);
        if (mq[f].size() == 0) return '0;
        return mq[f][0][95:32];
    endfunction

    function automatic logic [63:0] exp_lo(int f);
        int n = mq[f].size();
        int room = 16 - n;
        if (n == 0) return '0;
        if (room > 15) room = 15;
        return {7'b0, 5'(n), 4'(room), mrd[f], mwr[f], 8'b0, mq[f][0][31:0]};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ap_req = 0; ap_we = 0; ap_addr = '0; ap_wdata = '0;
        io_req = 0; io_we = 0; io_addr = '0; io_wdata = '0;
    endtask

    task automatic drive(int s, bit we, logic [7:0] a, logic [63:0] d);
        if (s == 0) begin ap_req = 1; ap_we = we; ap_addr = a; ap_wdata = d; end
        else        begin io_req = 1; io_we = we; io_addr = a; io_wdata = d; end
    endtask

    task automatic wr(int s, logic [7:0] a, logic [63:0] d);
        @(negedge clk); drive(s, 1'b1, a, d);
        @(posedge clk); #1; idle();
    endtask

    task automatic rd(int s, logic [7:0] a, output logic [63:0] d);
        @(negedge clk); drive(s, 1'b0, a, '0);
        #1 d = (s == 0) ? ap_rdata : io_rdata;
        @(posedge clk); #1; idle();
    endtask

    task automatic model_push(int f, logic [95:0] msg);
        if (mq[f].size() < 16) begin mq[f].push_back(msg); mwr[f] = mwr[f] + 4'd1; end
        else movf[f] = 1;
    endtask

    task automatic model_pop(int f);
        if (mq[f].size() > 0) begin void'(mq[f].pop_front()); mrd[f] = mrd[f] + 4'd1; end
    endtask

    task automatic send(int s, int f, logic [95:0] msg);
        wr(s, base(f) + 8'h10, msg[95:32]);
        wr(s, base(f) + 8'h18, {32'h0, msg[31:0]});
        model_push(f, msg);
    endtask

    task automatic pop_chk(int s, int f, string tag);
        logic [63:0] d;
        rd(s, base(f) + 8'h20, d); chk({tag, " upper word"}, d, exp_hi(f));
        rd(s, base(f) + 8'h28, d); chk({tag, " lower word"}, d, exp_lo(f));
        model_pop(f);
    endtask

    task automatic ctrl_chk(int s, int f, string tag);
        logic [63:0] d;
        rd(s, base(f), d); chk({tag, " control"}, d, exp_ctrl(f));
    endtask

    task automatic irq_chk(string tag, logic [3:0] exp);
        @(negedge clk);
        chk(tag, 64'({ap_irq_recv_ready, io_irq_send_empty, io_irq_recv_ready, ap_irq_send_empty}),
            64'(exp));
    endtask

    function automatic logic [95:0] rnd_msg();
        return {$urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        for (int f = 0; f < 2; f++) begin mrd[f] = 0; mwr[f] = 0; movf[f] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R9: reset state
        irq_chk("R9 irq lines after reset", 4'b0000);
        rd(0, 8'h48, v); chk("R9 enable after reset", v, 64'h0);
        ctrl_chk(0, 0, "R9 outbound");
        ctrl_chk(1, 1, "R9 inbound");
        chk("R9 control value", exp_ctrl(0), 64'h20000);

        // R7 / R8: latching interrupts
        wr(0, 8'h48, 64'hF);
        irq_chk("R8 both queues empty", 4'b0101);
        rd(1, 8'h4C, v); chk("R7 pending read", v, 64'h5);
        send(0, 0, 96'h1111_2222_3333_4444_5555_6666);
        irq_chk("R7 empty latched after push", 4'b0111);
        wr(1, 8'h4C, 64'h1);
        irq_chk("R7 ack clears stale empty", 4'b0110);
        pop_chk(1, 0, "R1 irq message");
        irq_chk("R7 not-empty latched after pop", 4'b0111);
        wr(0, 8'h4C, 64'h2);
        irq_chk("R7 ack clears stale not-empty", 4'b0101);
        wr(0, 8'h4C, 64'h1);
        irq_chk("R7 ack with live condition keeps pending", 4'b0101);
        rd(0, 8'h4C, v); chk("R7 pending after live ack", v, 64'h5);
        wr(1, 8'h48, 64'h1);
        irq_chk("R8 enable gates lines", 4'b0001);
        wr(0, 8'h48, 64'h0);
        irq_chk("R8 all disabled", 4'b0000);

        // R2: staging only
        wr(0, 8'h60, 64'hDEAD_BEEF_0123_4567);
        ctrl_chk(1, 0, "R2 upper write leaves queue empty");
        wr(0, 8'h68, 64'hFFFF_FFFF_AAAA_0001);
        model_push(0, {64'hDEAD_BEEF_0123_4567, 32'hAAAA_0001});
        wr(0, 8'h68, 64'h0000_0000_AAAA_0002);
        model_push(0, {64'hDEAD_BEEF_0123_4567, 32'hAAAA_0002});
        pop_chk(1, 0, "R2 staged word");
        pop_chk(1, 0, "R2 staged word reused");

        // R1: both directions independent
        send(1, 1, 96'hA1A1_A1A1_B2B2_B2B2_C3C3_C3C3);
        send(0, 0, 96'h0102_0304_0506_0708_090A_0B0C);
        send(1, 1, 96'hFEDC_BA98_7654_3210_0F0F_0F0F);
        ctrl_chk(0, 0, "R1 outbound level");
        ctrl_chk(0, 1, "R1 inbound level");
        pop_chk(0, 1, "R1 inbound first");
        pop_chk(1, 0, "R1 outbound");
        pop_chk(0, 1, "R1 inbound second");

        // R3: full, drop, overflow flag, R5 report at full
        for (int i = 0; i < 16; i++) send(0, 0, rnd_msg());
        ctrl_chk(1, 0, "R3 full");
        chk("R3 full value", exp_ctrl(0), 64'h10010);
        send(0, 0, 96'hBAD0_BAD0_BAD0_BAD0_BAD0_BAD0);
        ctrl_chk(1, 0, "R3 overflow set");
        wr(1, 8'h50, 64'h4_0000);
        movf[0] = 0;
        ctrl_chk(0, 0, "R3 overflow cleared");
        for (int i = 0; i < 16; i++) pop_chk(i % 2, 0, "R5 drain from full");

        // R4: empty reads and peeks
        rd(0, 8'h78, v); chk("R4 empty lower read", v, 64'h0);
        rd(1, 8'h70, v); chk("R4 empty upper read", v, 64'h0);
        ctrl_chk(0, 0, "R4 empty read did not move");
        send(1, 1, 96'h7777_8888_9999_AAAA_BBBB_CCCC);
        rd(0, 8'hA0, v); chk("R4 peek one", v, exp_hi(1));
        rd(0, 8'hA0, v); chk("R4 peek repeat", v, exp_hi(1));
        ctrl_chk(1, 1, "R4 peek left level");
        pop_chk(0, 1, "R4 after peek");

        // R6: same-cycle collisions
        wr(0, 8'h60, 64'hAAAA_AAAA_AAAA_AAAA);
        wr(1, 8'h60, 64'h5555_5555_5555_5555);
        @(negedge clk);
        drive(0, 1'b1, 8'h68, 64'h0000_0000_1234_5678);
        drive(1, 1'b1, 8'h68, 64'h0000_0000_8765_4321);
        @(posedge clk); #1; idle();
        model_push(0, {64'hAAAA_AAAA_AAAA_AAAA, 32'h1234_5678});
        movf[0] = 1;
        ctrl_chk(1, 0, "R6 push collision");
        pop_chk(1, 0, "R6 application push wins");
        wr(0, 8'h50, 64'h4_0000);
        movf[0] = 0;
        send(1, 1, rnd_msg());
        send(1, 1, rnd_msg());
        @(negedge clk);
        drive(0, 1'b0, 8'hA8, '0);
        drive(1, 1'b0, 8'hA8, '0);
        #1 va = ap_rdata; vb = io_rdata;
        @(posedge clk); #1; idle();
        chk("R6 pop collision application", va, exp_lo(1));
        chk("R6 pop collision io", vb, exp_lo(1));
        model_pop(1);
        ctrl_chk(0, 1, "R6 single pop");
        pop_chk(1, 1, "R6 remaining");

        // Random phase: R1/R3/R5 against the model
        seed = $urandom(32'd20240);
        for (int i = 0; i < 800; i++) begin
            op = $urandom_range(0, 9);
            side = $urandom_range(0, 1);
            fq = $urandom_range(0, 1);
            if ((i < 400 && op < 6) || (i >= 400 && op < 3)) begin
                m = rnd_msg();
                send(side, fq, m);
            end else if (op < 8 || (i >= 400 && op < 9)) begin
                pop_chk(side, fq, "R1 R5 random pop");
            end else begin
                if (movf[fq] && op == 9) begin
                    wr(side, base(fq), 64'h4_0000);
                    movf[fq] = 0;
                end
                ctrl_chk(side, fq, "R3 random status");
            end
        end

        for (int f = 0; f < 2; f++) begin
            while (mq[f].size() > 0) pop_chk(f, f, "R1 final drain");
            ctrl_chk(1 - f, f, "R4 final empty");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule